// File: doc/BRIEF.md
# PRBS Bit Error Detector with Error Classification

This block checks a serial bit stream, one bit per cycle when `din_valid` is high, against a pseudo-random reference sequence that it builds locally. It locks by itself. It loads its reference register with the first bits it receives. It then runs the register freely and requires an unbroken run of correct predictions before it declares lock. The default sequence follows the recurrence b[n] = b[n-7] XOR b[n-6].

Once locked, the block counts each mismatch as one of two kinds. A missing one is a bit where 1 was expected and 0 arrived. A spurious one is a bit where 0 was expected and 1 arrived. A total counter counts both kinds. When framing is enabled, each error is also counted by frame region: overhead or payload. A mask window of bit positions can be excluded from both locking and counting.

An automatic re-lock drops the lock when too many errors fall into one block of bits. A burst mode measures only a fixed number of cycles after each lock. An optional input inversion handles a stream sent with inverted polarity. All counters saturate, and a sticky flag records that a counter overflowed. A sticky history flag records that lock was lost. A `start` pulse begins a new measurement.

Top module: `ber_classifier`

## Requirements
- R1: After `start`, the first PRBS_N valid bits (default 7) load the reference. `locked` rises in the cycle after the valid bit with index PRBS_N+LOCK_RUN-1 (default 70, counting from 0 after `start`), provided every prediction from index PRBS_N onward was correct. `sync_loss` is always the inverse of `locked`.
- R2: While locked, a bit received as 0 where 1 is expected increments `cnt_omit`.
- R3: While locked, a bit received as 1 where 0 is expected increments `cnt_ins`. `cnt_total` counts both kinds, so it equals `cnt_omit + cnt_ins` until an overflow.
- R4: The frame position of a bit is its valid-bit index since `start`, modulo `frame_len`. With `frame_en` high, an error at a position below `ovhd_len` increments `cnt_ovhd`, and any other error increments `cnt_pay`. `cnt_frame_all` is their saturated sum. With `frame_en` low, both region counters stay unchanged.
- R5: With `mask_en` high, a mismatch at a position from `mask_lo` to `mask_hi` inclusive is never counted, and it does not break lock acquisition.
- R6: With `autosync_en` high, lock is dropped at the first locked bit that brings the errors in the current block above `rate_k`. Blocks are 2^`rate_m` valid bits long, and the first block begins with the first bit after lock. The bit that trips the limit is still counted. A new lock then follows the same rule as R1, starting with the next bit.
- R7: With `burst_en` high, errors are counted only during the `burst_len` clock cycles that follow each lock acquisition.
- R8: `data_err` is high in the cycle after each counted error, and low after a bit that was not counted.
- R9: `sync_hist` is set when an established lock is dropped. It stays set through later re-locks until the next `start`.
- R10: With `invert` high, the received bit is inverted before comparison. An inverted stream then locks and counts exactly as a true stream does. With `invert` low, an inverted stream never locks.
- R11: Counters hold at their maximum value instead of wrapping. `overflow` is set when an increment is lost and stays set until `start`.
- R12: `start` clears all counters, `overflow`, `sync_hist` and the frame position, and it restarts locking. No counter changes while the block is unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new measurement |
| din_valid | input | 1 | A data bit is present this cycle |
| din | input | 1 | Received data bit |
| invert | input | 1 | Invert the received bit before comparison |
| frame_en | input | 1 | Split counts into overhead and payload |
| frame_len | input | POS_W | Frame length in bits |
| ovhd_len | input | POS_W | Number of overhead bits at the start of each frame |
| mask_en | input | 1 | Enable the mask window |
| mask_lo | input | POS_W | First masked position |
| mask_hi | input | POS_W | Last masked position |
| autosync_en | input | 1 | Enable re-lock on high error rate |
| rate_k | input | KW | Largest tolerated error count per block |
| rate_m | input | MW | Block length exponent |
| burst_en | input | 1 | Count only within a window after each lock |
| burst_len | input | BURST_W | Length of the window in clock cycles |
| locked | output | 1 | Reference is locked |
| sync_loss | output | 1 | Reference is not locked |
| data_err | output | 1 | An error was counted in the previous cycle |
| sync_hist | output | 1 | Lock was lost since the last start |
| overflow | output | 1 | A counter saturated |
| cnt_omit | output | CNT_W | Missing-one error count |
| cnt_ins | output | CNT_W | Spurious-one error count |
| cnt_total | output | CNT_W | All counted errors |
| cnt_ovhd | output | CNT_W | Errors in the overhead region |
| cnt_pay | output | CNT_W | Errors in the payload region |
| cnt_frame_all | output | CNT_W | Saturated sum of the overhead and payload counts |

## Verification
The hardest state to reach from the ports is a drop of lock followed by a re-lock. To get there, the error limit must be crossed exactly inside one rate block, and then a clean stream must carry the block through a second full seed-and-check run. The bench sweeps `rate_k` over several values. For each value it injects one error more than the limit, on consecutive bits just after lock, so that all of them fall into the first block. It then checks the bit that triggers the drop, the bit that restores lock 71 bits later, and that the history flag survives the re-lock. The bench generates its own reference stream from the recurrence. It predicts every count from the positions, regions and true values of the bits it flips.

// File: rtl/ber_cls_pkg.sv
package ber_cls_pkg;

  typedef enum logic [1:0] {
    ST_SEED  = 2'd0,
    ST_CHECK = 2'd1,
    ST_LOCK  = 2'd2
  } sync_st_t;

  // increment strobes, one per counter; bit order fixes counter index
  typedef struct packed {
    logic total;  // [4]
    logic omit;   // [3]
    logic ins;    // [2]
    logic ovhd;   // [1]
    logic pay;    // [0]
  } err_inc_t;

  localparam int NUM_CTR = 5;

endpackage

// File: rtl/ber_sat_ctr.sv
module ber_sat_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count,
  output logic         sat_hit
);

  localparam logic [W-1:0] MAXV = '1;

  assign sat_hit = inc && !clr && (count == MAXV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       count <= '0;
    else if (clr)                     count <= '0;
    else if (inc && (count != MAXV))  count <= count + 1'b1;
  end

endmodule

// File: rtl/ber_ref_gen.sv
module ber_ref_gen #(
  parameter int N   = 7,
  parameter int TAP = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift,
  input  logic load_rx,
  input  logic rx_bit,
  output logic exp_bit
);

  logic [N-1:0] hist;  // hist[0] newest bit

  function automatic logic predict(input logic [N-1:0] h);
    return h[N-1] ^ h[TAP-1];
  endfunction

  assign exp_bit = predict(hist);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hist <= '0;
    else if (shift) hist <= {hist[N-2:0], (load_rx ? rx_bit : exp_bit)};
  end

endmodule

// File: rtl/ber_sync_ctl.sv
module ber_sync_ctl
  import ber_cls_pkg::*;
#(
  parameter int N           = 7,
  parameter int LOCK_RUN    = 64,
  parameter int BLK_LOG_MAX = 16,
  parameter int KW          = 8,
  parameter int MW          = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          valid,
  input  logic          mism,
  input  logic          autosync_en,
  input  logic [KW-1:0] rate_k,
  input  logic [MW-1:0] rate_m,
  output logic          locked,
  output logic          seeding,
  output logic          lock_gain,
  output logic          lock_drop
);

  localparam int SEED_W = $clog2(N + 1);
  localparam int RUN_W  = $clog2(LOCK_RUN + 1);

  sync_st_t                 state;
  logic [SEED_W-1:0]        seed_cnt;
  logic [RUN_W-1:0]         run_cnt;
  logic [BLK_LOG_MAX-1:0]   blk_cnt;
  logic [KW:0]              blk_err;
  logic [KW:0]              blk_err_nxt;
  logic                     blk_last;
  logic                     rate_trip;

  function automatic logic at_block_end(input logic [BLK_LOG_MAX-1:0] cnt,
                                        input logic [MW-1:0] m);
    logic [BLK_LOG_MAX-1:0] lim;
    lim = ~({BLK_LOG_MAX{1'b1}} << m);
    return cnt == lim;
  endfunction

  assign blk_err_nxt = blk_err + {{KW{1'b0}}, mism};
  assign blk_last    = at_block_end(blk_cnt, rate_m);
  assign rate_trip   = autosync_en && (blk_err_nxt > {1'b0, rate_k});

  assign locked    = (state == ST_LOCK);
  assign seeding   = (state == ST_SEED);
  assign lock_gain = (state == ST_CHECK) && valid && !start && !mism &&
                     (run_cnt == RUN_W'(LOCK_RUN - 1));
  assign lock_drop = (state == ST_LOCK) && valid && !start && rate_trip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_SEED;
      seed_cnt <= '0;
      run_cnt  <= '0;
      blk_cnt  <= '0;
      blk_err  <= '0;
    end else if (start) begin
      state    <= ST_SEED;
      seed_cnt <= '0;
      run_cnt  <= '0;
      blk_cnt  <= '0;
      blk_err  <= '0;
    end else if (valid) begin
      case (state)
        ST_SEED: begin
          if (seed_cnt == SEED_W'(N - 1)) begin
            state   <= ST_CHECK;
            run_cnt <= '0;
          end else begin
            seed_cnt <= seed_cnt + 1'b1;
          end
        end
        ST_CHECK: begin
          if (mism) begin
            state    <= ST_SEED;
            seed_cnt <= '0;
          end else if (lock_gain) begin
            state   <= ST_LOCK;
            blk_cnt <= '0;
            blk_err <= '0;
          end else begin
            run_cnt <= run_cnt + 1'b1;
          end
        end
        ST_LOCK: begin
          if (lock_drop) begin
            state    <= ST_SEED;
            seed_cnt <= '0;
          end else if (blk_last) begin
            blk_cnt <= '0;
            blk_err <= '0;
          end else begin
            blk_cnt <= blk_cnt + 1'b1;
            blk_err <= blk_err_nxt;
          end
        end
        default: state <= ST_SEED;
      endcase
    end
  end

endmodule

// File: rtl/ber_classifier.sv
module ber_classifier
  import ber_cls_pkg::*;
#(
  parameter int PRBS_N      = 7,
  parameter int PRBS_TAP    = 6,
  parameter int LOCK_RUN    = 64,
  parameter int CNT_W       = 16,
  parameter int POS_W       = 16,
  parameter int KW          = 8,
  parameter int BLK_LOG_MAX = 16,
  parameter int MW          = $clog2(BLK_LOG_MAX + 1),
  parameter int BURST_W     = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               din_valid,
  input  logic               din,
  input  logic               invert,
  input  logic               frame_en,
  input  logic [POS_W-1:0]   frame_len,
  input  logic [POS_W-1:0]   ovhd_len,
  input  logic               mask_en,
  input  logic [POS_W-1:0]   mask_lo,
  input  logic [POS_W-1:0]   mask_hi,
  input  logic               autosync_en,
  input  logic [KW-1:0]      rate_k,
  input  logic [MW-1:0]      rate_m,
  input  logic               burst_en,
  input  logic [BURST_W-1:0] burst_len,
  output logic               locked,
  output logic               sync_loss,
  output logic               data_err,
  output logic               sync_hist,
  output logic               overflow,
  output logic [CNT_W-1:0]   cnt_omit,
  output logic [CNT_W-1:0]   cnt_ins,
  output logic [CNT_W-1:0]   cnt_total,
  output logic [CNT_W-1:0]   cnt_ovhd,
  output logic [CNT_W-1:0]   cnt_pay,
  output logic [CNT_W-1:0]   cnt_frame_all
);

  // named internal events
  logic               rx_bit;
  logic               exp_bit;
  logic               seeding;
  logic               lock_gain;
  logic               lock_drop;
  logic               in_mask;
  logic               in_ovhd;
  logic               mism;
  logic               measuring;
  logic               count_ev;
  logic [POS_W-1:0]   pos;
  logic [BURST_W-1:0] burst_cnt;
  err_inc_t           inc_s;
  logic [NUM_CTR-1:0] inc_v;
  logic [NUM_CTR-1:0] sat_v;
  logic [CNT_W-1:0]   ctr_val [NUM_CTR];

  function automatic logic in_window(input logic [POS_W-1:0] p,
                                     input logic [POS_W-1:0] lo,
                                     input logic [POS_W-1:0] hi);
    return (p >= lo) && (p <= hi);
  endfunction

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                               input logic [CNT_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CNT_W] ? {CNT_W{1'b1}} : s[CNT_W-1:0];
  endfunction

  function automatic logic [POS_W-1:0] pos_next(input logic [POS_W-1:0] p,
                                                input logic [POS_W-1:0] len);
    return (p >= len - 1'b1) ? '0 : p + 1'b1;
  endfunction

  assign rx_bit  = din ^ invert;
  assign in_mask = mask_en && in_window(pos, mask_lo, mask_hi);
  assign in_ovhd = (pos < ovhd_len);
  assign mism    = (rx_bit ^ exp_bit) && !in_mask;

  ber_ref_gen #(
    .N   (PRBS_N),
    .TAP (PRBS_TAP)
  ) u_ref (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift   (din_valid && !start),
    .load_rx (seeding),
    .rx_bit  (rx_bit),
    .exp_bit (exp_bit)
  );

  ber_sync_ctl #(
    .N           (PRBS_N),
    .LOCK_RUN    (LOCK_RUN),
    .BLK_LOG_MAX (BLK_LOG_MAX),
    .KW          (KW),
    .MW          (MW)
  ) u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .valid       (din_valid),
    .mism        (mism),
    .autosync_en (autosync_en),
    .rate_k      (rate_k),
    .rate_m      (rate_m),
    .locked      (locked),
    .seeding     (seeding),
    .lock_gain   (lock_gain),
    .lock_drop   (lock_drop)
  );

  // frame position: valid bits since start, modulo frame_len
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pos <= '0;
    else if (start)     pos <= '0;
    else if (din_valid) pos <= pos_next(pos, frame_len);
  end

  // burst window timer, reloaded at each lock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                burst_cnt <= '0;
    else if (start)            burst_cnt <= '0;
    else if (lock_gain)        burst_cnt <= burst_len;
    else if (burst_cnt != '0)  burst_cnt <= burst_cnt - 1'b1;
  end

  assign measuring = !burst_en || (burst_cnt != '0);
  assign count_ev  = locked && din_valid && !start && mism && measuring;

  always_comb begin
    inc_s.total = count_ev;
    inc_s.omit  = count_ev && exp_bit;
    inc_s.ins   = count_ev && !exp_bit;
    inc_s.ovhd  = count_ev && frame_en && in_ovhd;
    inc_s.pay   = count_ev && frame_en && !in_ovhd;
  end
  assign inc_v = inc_s;

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    ber_sat_ctr #(.W(CNT_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start),
      .inc     (inc_v[g]),
      .count   (ctr_val[g]),
      .sat_hit (sat_v[g])
    );
  end

  assign cnt_total     = ctr_val[4];
  assign cnt_omit      = ctr_val[3];
  assign cnt_ins       = ctr_val[2];
  assign cnt_ovhd      = ctr_val[1];
  assign cnt_pay       = ctr_val[0];
  assign cnt_frame_all = sat_add(cnt_ovhd, cnt_pay);
  assign sync_loss     = !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_err  <= 1'b0;
      sync_hist <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      data_err <= count_ev;
      if (start)          sync_hist <= 1'b0;
      else if (lock_drop) sync_hist <= 1'b1;
      if (start)          overflow <= 1'b0;
      else if (|sat_v)    overflow <= 1'b1;
    end
  end

endmodule

// File: rtl/ber_classifier_chk.sv
module ber_classifier_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             frame_en,
  input logic             locked,
  input logic             data_err,
  input logic             sync_hist,
  input logic             overflow,
  input logic             lock_drop,
  input logic [CNT_W-1:0] cnt_omit,
  input logic [CNT_W-1:0] cnt_ins,
  input logic [CNT_W-1:0] cnt_total,
  input logic [CNT_W-1:0] cnt_ovhd,
  input logic [CNT_W-1:0] cnt_pay
);

  AST_TOTAL_IS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    !overflow |-> ({1'b0, cnt_total} == {1'b0, cnt_omit} + {1'b0, cnt_ins})); // R3

  AST_FRAME_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_en && !start) |=> ($stable(cnt_ovhd) && $stable(cnt_pay))); // R4

  AST_NO_COUNT_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !start) |=> $stable(cnt_total)); // R12

  AST_DERR_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    data_err |-> $past(locked)); // R8

  AST_DROP_SETS_HIST: assert property (@(posedge clk) disable iff (!rst_n)
    lock_drop |=> (sync_hist && !locked)); // R9

  AST_HIST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_hist && !start) |=> sync_hist); // R9

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !start) |=> overflow); // R11

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (cnt_total >= $past(cnt_total))); // R11

endmodule

bind ber_classifier ber_classifier_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .frame_en  (frame_en),
  .locked    (locked),
  .data_err  (data_err),
  .sync_hist (sync_hist),
  .overflow  (overflow),
  .lock_drop (lock_drop),
  .cnt_omit  (cnt_omit),
  .cnt_ins   (cnt_ins),
  .cnt_total (cnt_total),
  .cnt_ovhd  (cnt_ovhd),
  .cnt_pay   (cnt_pay)
);

// File: tb/test_ber_classifier.sv
module test_ber_classifier;

  localparam int CLK_PERIOD = 10;
  localparam int CW  = 8;
  localparam int PW  = 16;
  localparam int KW  = 8;
  localparam int MW  = 5;
  localparam int BW  = 20;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, din_valid = 1'b0, din = 1'b0, invert = 1'b0;
  logic frame_en = 1'b0, mask_en = 1'b0, autosync_en = 1'b0, burst_en = 1'b0;
  logic [PW-1:0] frame_len = 16'd20, ovhd_len = 16'd4, mask_lo = 16'd0, mask_hi = 16'd0;
  logic [KW-1:0] rate_k = '0;
  logic [MW-1:0] rate_m = 5'd4;
  logic [BW-1:0] burst_len = '0;
  logic locked, sync_loss, data_err, sync_hist, overflow;
  logic [CW-1:0] cnt_omit, cnt_ins, cnt_total, cnt_ovhd, cnt_pay, cnt_frame_all;

  always #(CLK_PERIOD/2) clk = ~clk;

  ber_classifier #(.CNT_W(CW)) i_ber_classifier (
    .clk(clk), .rst_n(rst_n), .start(start), .din_valid(din_valid), .din(din),
    .invert(invert), .frame_en(frame_en), .frame_len(frame_len), .ovhd_len(ovhd_len),
    .mask_en(mask_en), .mask_lo(mask_lo), .mask_hi(mask_hi),
    .autosync_en(autosync_en), .rate_k(rate_k), .rate_m(rate_m),
    .burst_en(burst_en), .burst_len(burst_len),
    .locked(locked), .sync_loss(sync_loss), .data_err(data_err), .sync_hist(sync_hist),
    .overflow(overflow), .cnt_omit(cnt_omit), .cnt_ins(cnt_ins), .cnt_total(cnt_total),
    .cnt_ovhd(cnt_ovhd), .cnt_pay(cnt_pay), .cnt_frame_all(cnt_frame_all)
  );

  int checks = 0, errors = 0;
  int bidx = 0;
  int e_omit = 0, e_ins = 0, e_tot = 0, e_ovhd = 0, e_pay = 0;
  int meas_from = 0, meas_to = 0;
  bit derr_chk = 1'b1;
  bit comp = 1'b0;
  bit flipset [512];
  logic [6:0] gh = 7'h40;  // bench copy of the recurrence b[n]=b[n-7]^b[n-6]

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (bit %0d)", tag, act, exp, bidx);
    end
  endtask

  function automatic int sat(input int v);
    return (v > MAXC) ? MAXC : v;
  endfunction

  task automatic send_one();
    logic tb;
    bit f, counted;
    int p;
    tb = gh[6] ^ gh[5];
    gh = {gh[5:0], tb};
    f = flipset[bidx];
    @(negedge clk);
    din = tb ^ f ^ comp;
    din_valid = 1'b1;
    @(posedge clk);
    #1;
    p = bidx % int'(frame_len);
    counted = f && (bidx >= meas_from) && (bidx < meas_to) &&
              !(mask_en && p >= int'(mask_lo) && p <= int'(mask_hi));
    if (counted) begin
      e_tot++;
      if (tb) e_omit++; else e_ins++;
      if (frame_en) begin
        if (p < int'(ovhd_len)) e_ovhd++; else e_pay++;
      end
    end
    if (derr_chk) check("R8 data_err", int'(data_err), int'(counted));
    bidx++;
  endtask

  task automatic run_to(input int last);
    while (bidx <= last) send_one();
  endtask

  task automatic do_start();
    @(negedge clk);
    din_valid = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    bidx = 0;
    e_omit = 0; e_ins = 0; e_tot = 0; e_ovhd = 0; e_pay = 0;
    for (int i = 0; i < 512; i++) flipset[i] = 1'b0;
  endtask

  task automatic check_counts(input string tag);
    check({tag, " R2 omit"},  int'(cnt_omit),  sat(e_omit));
    check({tag, " R3 ins"},   int'(cnt_ins),   sat(e_ins));
    check({tag, " R3 total"}, int'(cnt_total), sat(e_tot));
    check({tag, " R4 ovhd"},  int'(cnt_ovhd),  sat(e_ovhd));
    check({tag, " R4 pay"},   int'(cnt_pay),   sat(e_pay));
    check({tag, " R4 all"},   int'(cnt_frame_all), sat(sat(e_ovhd) + sat(e_pay)));
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    check("R12 reset total", int'(cnt_total), 0);
    check("R1 reset locked", int'(locked), 0);
    check("R1 reset sync_loss", int'(sync_loss), 1);
    check("R9 reset hist", int'(sync_hist), 0);
    rst_n = 1'b1;

    // T1: lock timing and polarity classification, framing off
    do_start();
    meas_from = 71; meas_to = 100000;
    flipset[80] = 1; flipset[81] = 1; flipset[90] = 1;
    flipset[95] = 1; flipset[100] = 1; flipset[120] = 1; flipset[121] = 1;
    run_to(69);
    check("R1 not yet locked", int'(locked), 0);
    run_to(70);
    check("R1 locked", int'(locked), 1);
    check("R1 sync_loss", int'(sync_loss), 0);
    run_to(199);
    check_counts("T1");
    check("R9 no loss hist", int'(sync_hist), 0);

    // T2: framing and mask (mask 10..12 of a 20-bit frame, overhead 0..3)
    do_start();
    frame_en = 1; mask_en = 1; mask_lo = 10; mask_hi = 12;
    flipset[31] = 1;                       // masked error during checking
    flipset[91] = 1; flipset[92] = 1; flipset[130] = 1;  // masked after lock
    flipset[95] = 1; flipset[102] = 1; flipset[123] = 1; flipset[139] = 1;
    run_to(69);
    check("R5 masked check error no lock yet", int'(locked), 0);
    run_to(70);
    check("R5 lock despite masked error", int'(locked), 1);
    run_to(159);
    check_counts("T2");
    frame_en = 0; mask_en = 0;

    // T3: inverted stream
    do_start();
    comp = 1; invert = 0;
    run_to(199);
    check("R10 inverted stream no lock", int'(locked), 0);
    check("R12 unlocked no count", int'(cnt_total), 0);
    do_start();
    invert = 1;
    flipset[100] = 1; flipset[110] = 1;
    run_to(70);
    check("R10 inverted lock", int'(locked), 1);
    run_to(149);
    check_counts("T3 R10");
    comp = 0; invert = 0;

    // T4: auto re-lock sweep over the error limit, block of 16 bits
    autosync_en = 1; rate_m = 4;
    for (int k = 0; k < 4; k++) begin
      do_start();
      rate_k = KW'(k);
      meas_from = 71; meas_to = 73 + k;
      for (int j = 0; j <= k; j++) flipset[72 + j] = 1;
      run_to(71 + k);
      check("R6 within limit stays locked", int'(locked), 1);
      run_to(72 + k);
      check("R6 limit exceeded drops lock", int'(locked), 0);
      check("R9 hist set on drop", int'(sync_hist), 1);
      check("R6 tripping bit counted", int'(cnt_total), k + 1);
      run_to(72 + k + 70);
      check("R6 relock not early", int'(locked), 0);
      run_to(72 + k + 71);
      check("R6 relock", int'(locked), 1);
      check("R9 hist kept after relock", int'(sync_hist), 1);
    end
    do_start();
    #1;
    check("R9 start clears hist", int'(sync_hist), 0);
    autosync_en = 0;

    // T5: burst window of 10 cycles after lock
    do_start();
    burst_en = 1; burst_len = 10;
    meas_from = 71; meas_to = 81;
    flipset[72] = 1; flipset[80] = 1; flipset[81] = 1; flipset[95] = 1;
    run_to(120);
    check_counts("T5 R7");
    burst_en = 0;

    // T6: saturation with every bit in error, no auto re-lock
    do_start();
    meas_from = 71; meas_to = 100000;
    for (int i = 71; i < 400; i++) flipset[i] = 1;
    run_to(399);
    check_counts("T6 R11");
    check("R11 overflow set", int'(overflow), 1);
    check("R11 still locked", int'(locked), 1);
    do_start();
    #1;
    check("R12 start clears total", int'(cnt_total), 0);
    check("R11 start clears overflow", int'(overflow), 0);
    check("R12 start clears lock", int'(locked), 0);

    finish_run();
  end

endmodule